// File: doc/BRIEF.md
# Read/Write Ordering Gate for a Data Memory Port

This block sits between a load/store unit and the read and write request channels of an AXI4-lite data path. For each new read or write request it decides whether the request may issue now, based on the requests already issued and not yet completed. It watches the request handshakes (valid and ready both high) and the completion handshakes on the read data and write response channels. From these it keeps one in-flight table per direction, holding the word address of every open transaction.

A static parameter picks one of two policies. With `ORDER_MODE = 0` the two directions never overlap: an open write holds back every read and an open read holds back every write. With `ORDER_MODE = 1` reads and writes may be in flight together. A new request is held only while its word address matches an open entry in the other direction's table, or while its own table is full. A completion that arrives on a direction with no open entry is a protocol fault, and the block reports it on a per-direction pulse output.

Top module: `axi_order_gate`

## Requirements
- R1: After a synchronous active-low reset, both tables are empty, both fault outputs are low, and both ready outputs are high whenever no other rule holds them.
- R2: With ORDER_MODE=0, a read is not accepted while any write is open and a write is not accepted while any read is open. When a read request is valid, a write is not accepted in that cycle, so a read wins a same-cycle contest.
- R3: With ORDER_MODE=1, a read and a write to different word addresses may both be open at the same time.
- R4: With ORDER_MODE=1, a request is held while its word address matches an open entry of the other direction. Address bits [1:0] are ignored in this comparison. A same-cycle read and write to the same word accept the read and hold the write.
- R5: Each table holds DEPTH entries (default 4). A request is held while its own table is full, even when there is no address match.
- R6: An entry is freed only on a completion handshake, where the completion valid and ready inputs are both high. Entries are freed in the order their requests were accepted.
- R7: A completion handshake on a direction whose table is empty sets that direction's fault output high for exactly the following cycle and changes no table.
- R8: A request is recorded only on a clock edge where its valid and ready are both high. A held request leaves no entry behind.
- R9: Readiness depends on the table contents at the start of the cycle. A completion in the same cycle frees a slot or clears a match only from the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| rd_req_valid | input | 1 | Read request offered |
| rd_req_ready | output | 1 | Read request may issue this cycle |
| rd_req_addr | input | ADDR_W | Read byte address |
| wr_req_valid | input | 1 | Write request offered |
| wr_req_ready | output | 1 | Write request may issue this cycle |
| wr_req_addr | input | ADDR_W | Write byte address |
| rd_cpl_valid | input | 1 | Read data beat valid (completion) |
| rd_cpl_ready | input | 1 | Read data beat taken |
| wr_cpl_valid | input | 1 | Write response valid (completion) |
| wr_cpl_ready | input | 1 | Write response taken |
| rd_cpl_err | output | 1 | One-cycle pulse: read completion with no open read |
| wr_cpl_err | output | 1 | One-cycle pulse: write completion with no open write |

## Verification
The table assertions assume that the environment never forces a request in while ready is low. That is what makes a full-table push impossible, and it is also why the live-entry count tracks the occupancy counter. The stimulus honours this by treating a request as issued only when the design's ready is high. Completions, however, are driven freely, even when a table is empty, so the fault path is exercised. Addresses come from a small pool of words with random byte offsets, which makes collisions and same-cycle contests frequent in both modes.

// File: rtl/axo_pkg.sv
`timescale 1ns/1ps
// Package: shared types for the read/write ordering gate.
// Assumes nothing beyond standard packed types.
package axo_pkg;

    typedef enum logic {
        ORD_SERIAL = 1'b0,
        ORD_CONCUR = 1'b1
    } order_mode_e;

    typedef struct packed {
        logic full;
        logic empty;
    } tbl_stat_t;

endpackage

// File: rtl/inflight_table.sv
`timescale 1ns/1ps
// Module: inflight_table
// Keeps the keys of open transactions for one direction, oldest first.
// A push records a key, and a completion frees the oldest entry. The block
// also reports whether a query key matches any open entry. A completion
// while the table is empty is dropped and flagged one cycle later.
// Assumes: push is never raised while the table is full.
module inflight_table
    import axo_pkg::*;
#(
    parameter int DEPTH = 4,
    parameter int KEY_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  logic [KEY_W-1:0] push_key,
    input  logic             cpl,
    input  logic [KEY_W-1:0] query_key,
    output tbl_stat_t        stat,
    output logic             hit,
    output logic             orphan
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH + 1);

    logic [KEY_W-1:0] slot [DEPTH];
    logic [DEPTH-1:0] live;
    logic [DEPTH-1:0] match;
    logic [PTR_W-1:0] head, tail;
    logic [CNT_W-1:0] count;
    logic             pop;

    function automatic logic [PTR_W-1:0] wrap_inc(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    // Occupancy flags derived from the counter
    always_comb begin
        stat.empty = (count == '0);
        stat.full  = (count == CNT_W'(DEPTH));
        pop        = cpl && !stat.empty;
    end

    // Per-slot comparison of the query key against open entries
    for (genvar i = 0; i < DEPTH; i++) begin : g_cmp
        assign match[i] = live[i] && (slot[i] == query_key);
    end
    assign hit = |match;

    // Pointer, occupancy, live-bit and fault-flag registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            head   <= '0;
            tail   <= '0;
            count  <= '0;
            live   <= '0;
            orphan <= 1'b0;
        end else begin
            orphan <= cpl && stat.empty;
            if (pop) begin
                head       <= wrap_inc(head);
                live[head] <= 1'b0;
            end
            if (push) begin
                tail       <= wrap_inc(tail);
                live[tail] <= 1'b1;
            end
            case ({push, pop})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end

    // Key storage, written at the tail on each accepted request
    always_ff @(posedge clk) begin
        if (push) slot[tail] <= push_key;
    end

    p_no_overflow_r5: assert property (@(posedge clk) disable iff (!rst_n)
        stat.full |-> !push);

    p_live_matches_count_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(live) == 32'(count));

    p_orphan_no_change_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (cpl && stat.empty && !push) |=> (count == '0));

endmodule

// File: rtl/order_policy.sv
`timescale 1ns/1ps
// Module: order_policy
// Turns the table state into request readiness. Both policies are computed,
// and the ORDER_MODE parameter selects one of them. Reads take priority
// over writes in every same-cycle contest.
// Assumes the status and hit inputs reflect registered table contents only.
module order_policy
    import axo_pkg::*;
#(
    parameter int ORDER_MODE = 1
) (
    input  logic      rd_req_valid,
    input  logic      same_word,
    input  tbl_stat_t rd_stat,
    input  tbl_stat_t wr_stat,
    input  logic      rd_hits_wr,
    input  logic      wr_hits_rd,
    output logic      rd_ready,
    output logic      wr_ready
);
    logic ser_rd, ser_wr, con_rd, con_wr;

    // Readiness under both policies
    always_comb begin
        ser_rd = !rd_stat.full && wr_stat.empty;
        ser_wr = !wr_stat.full && rd_stat.empty && !rd_req_valid;
        con_rd = !rd_stat.full && !rd_hits_wr;
        con_wr = !wr_stat.full && !wr_hits_rd && !(rd_req_valid && con_rd && same_word);
    end

    if (ORDER_MODE == int'(ORD_SERIAL)) begin : g_serial
        assign rd_ready = ser_rd;
        assign wr_ready = ser_wr;
    end else begin : g_concur
        assign rd_ready = con_rd;
        assign wr_ready = con_wr;
    end

endmodule

// File: rtl/axi_order_gate.sv
`timescale 1ns/1ps
// Module: axi_order_gate
// Gates read and write request issue so that reads and writes are ordered
// with respect to each other. ORDER_MODE=0 serialises the two directions.
// ORDER_MODE=1 lets them overlap unless the word addresses collide.
// Completions with no open entry are flagged per direction.
// Assumes: the requester keeps valid and the address stable until accepted.
module axi_order_gate
    import axo_pkg::*;
#(
    parameter int ORDER_MODE  = 1,
    parameter int DEPTH       = 4,
    parameter int ADDR_W      = 32,
    parameter int OFFSET_BITS = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_req_valid,
    output logic              rd_req_ready,
    input  logic [ADDR_W-1:0] rd_req_addr,
    input  logic              wr_req_valid,
    output logic              wr_req_ready,
    input  logic [ADDR_W-1:0] wr_req_addr,
    input  logic              rd_cpl_valid,
    input  logic              rd_cpl_ready,
    input  logic              wr_cpl_valid,
    input  logic              wr_cpl_ready,
    output logic              rd_cpl_err,
    output logic              wr_cpl_err
);
    localparam logic [ADDR_W-1:0] WORD_MASK = ~((ADDR_W'(1) << OFFSET_BITS) - 1'b1);

    logic [ADDR_W-1:0] rd_key, wr_key;
    logic              rd_fire, wr_fire;
    logic              rd_hits_wr, wr_hits_rd;
    tbl_stat_t         rd_stat, wr_stat;

    // Word keys and handshakes
    always_comb begin
        rd_key  = rd_req_addr & WORD_MASK;
        wr_key  = wr_req_addr & WORD_MASK;
        rd_fire = rd_req_valid && rd_req_ready;
        wr_fire = wr_req_valid && wr_req_ready;
    end

    inflight_table #(.DEPTH(DEPTH), .KEY_W(ADDR_W)) u_rd_tbl (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (rd_fire),
        .push_key  (rd_key),
        .cpl       (rd_cpl_valid && rd_cpl_ready),
        .query_key (wr_key),
        .stat      (rd_stat),
        .hit       (wr_hits_rd),
        .orphan    (rd_cpl_err)
    );

    inflight_table #(.DEPTH(DEPTH), .KEY_W(ADDR_W)) u_wr_tbl (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (wr_fire),
        .push_key  (wr_key),
        .cpl       (wr_cpl_valid && wr_cpl_ready),
        .query_key (rd_key),
        .stat      (wr_stat),
        .hit       (rd_hits_wr),
        .orphan    (wr_cpl_err)
    );

    order_policy #(.ORDER_MODE(ORDER_MODE)) u_policy (
        .rd_req_valid (rd_req_valid),
        .same_word    (rd_key == wr_key),
        .rd_stat      (rd_stat),
        .wr_stat      (wr_stat),
        .rd_hits_wr   (rd_hits_wr),
        .wr_hits_rd   (wr_hits_rd),
        .rd_ready     (rd_req_ready),
        .wr_ready     (wr_req_ready)
    );

    if (ORDER_MODE == int'(ORD_SERIAL)) begin : g_chk_serial
        p_never_both_open_r2: assert property (@(posedge clk) disable iff (!rst_n)
            rd_stat.empty || wr_stat.empty);
        p_no_dual_issue_r2: assert property (@(posedge clk) disable iff (!rst_n)
            !(rd_fire && wr_fire));
    end else begin : g_chk_concur
        p_dual_issue_distinct_r4: assert property (@(posedge clk) disable iff (!rst_n)
            (rd_fire && wr_fire) |-> (rd_key != wr_key));
    end

endmodule

// File: tb/sim_axi_order_gate.sv
`timescale 1ns/1ps
// Bench: drives one concurrent-mode instance (u0) and one serialized
// instance (u1) from shared stimulus and compares both with a model.
module sim_axi_order_gate;
    localparam int DEPTH = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        rv = 0, wv = 0, rcv = 0, rcr = 0, wcv = 0, wcr = 0;
    logic [31:0] ra = '0, wa = '0;
    logic [1:0]  rrdy, wrdy, rerr, werr;

    int checks = 0;
    int errors = 0;

    // model state, index 0 = concurrent, 1 = serialized
    int          rc [2];
    int          wc [2];
    logic [29:0] rq [2][DEPTH];
    logic [29:0] wq [2][DEPTH];
    bit          rerr_exp [2];
    bit          werr_exp [2];

    always #2.5 clk = ~clk;

    axi_order_gate #(.ORDER_MODE(1), .DEPTH(DEPTH)) u0 (
        .clk(clk), .rst_n(rst_n),
        .rd_req_valid(rv), .rd_req_ready(rrdy[0]), .rd_req_addr(ra),
        .wr_req_valid(wv), .wr_req_ready(wrdy[0]), .wr_req_addr(wa),
        .rd_cpl_valid(rcv), .rd_cpl_ready(rcr),
        .wr_cpl_valid(wcv), .wr_cpl_ready(wcr),
        .rd_cpl_err(rerr[0]), .wr_cpl_err(werr[0])
    );

    axi_order_gate #(.ORDER_MODE(0), .DEPTH(DEPTH)) u1 (
        .clk(clk), .rst_n(rst_n),
        .rd_req_valid(rv), .rd_req_ready(rrdy[1]), .rd_req_addr(ra),
        .wr_req_valid(wv), .wr_req_ready(wrdy[1]), .wr_req_addr(wa),
        .rd_cpl_valid(rcv), .rd_cpl_ready(rcr),
        .wr_cpl_valid(wcv), .wr_cpl_ready(wcr),
        .rd_cpl_err(rerr[1]), .wr_cpl_err(werr[1])
    );

    function automatic bit open_match(input int d, input bit in_wr, input logic [29:0] w);
        bit m = 0;
        for (int i = 0; i < DEPTH; i++) begin
            if (in_wr && i < wc[d] && wq[d][i] == w) m = 1;
            if (!in_wr && i < rc[d] && rq[d][i] == w) m = 1;
        end
        return m;
    endfunction

    function automatic bit exp_rrdy(input int d);
        if (d == 1) return (rc[d] < DEPTH) && (wc[d] == 0);
        return (rc[d] < DEPTH) && !open_match(d, 1, ra[31:2]);
    endfunction

    function automatic bit exp_wrdy(input int d);
        if (d == 1) return (wc[d] < DEPTH) && (rc[d] == 0) && !rv;
        return (wc[d] < DEPTH) && !open_match(d, 0, wa[31:2])
               && !(rv && exp_rrdy(0) && ra[31:2] == wa[31:2]);
    endfunction

    task automatic check(input string tag, input string what, input int d,
                         input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s dut%0d actual %0b expected %0b", tag, what, d, act, exp);
        end
    endtask

    task automatic step(input string tag, input logic r_v, input logic [31:0] r_a,
                        input logic w_v, input logic [31:0] w_a,
                        input logic r_cv, input logic r_cr,
                        input logic w_cv, input logic w_cr);
        bit rf [2];
        bit wf [2];
        @(negedge clk);
        rv = r_v; ra = r_a; wv = w_v; wa = w_a;
        rcv = r_cv; rcr = r_cr; wcv = w_cv; wcr = w_cr;
        #1;
        for (int d = 0; d < 2; d++) begin
            check(tag, "rd_ready", d, rrdy[d], exp_rrdy(d));
            check(tag, "wr_ready", d, wrdy[d], exp_wrdy(d));
            check("R7", "rd_err", d, rerr[d], rerr_exp[d]);
            check("R7", "wr_err", d, werr[d], werr_exp[d]);
            rf[d] = r_v && exp_rrdy(d);
            wf[d] = w_v && exp_wrdy(d);
        end
        for (int d = 0; d < 2; d++) begin
            rerr_exp[d] = r_cv && r_cr && rc[d] == 0;
            werr_exp[d] = w_cv && w_cr && wc[d] == 0;
            if (r_cv && r_cr && rc[d] > 0) begin
                for (int i = 0; i < DEPTH - 1; i++) rq[d][i] = rq[d][i+1];
                rc[d]--;
            end
            if (w_cv && w_cr && wc[d] > 0) begin
                for (int i = 0; i < DEPTH - 1; i++) wq[d][i] = wq[d][i+1];
                wc[d]--;
            end
            if (rf[d]) begin rq[d][rc[d]] = r_a[31:2]; rc[d]++; end
            if (wf[d]) begin wq[d][wc[d]] = w_a[31:2]; wc[d]++; end
        end
    endtask

    task automatic drain();
        while (rc[0] + wc[0] + rc[1] + wc[1] > 0)
            step("R6", 0, '0, 0, '0, 1, 1, 1, 1);
        step("R6", 0, '0, 0, '0, 0, 0, 0, 0);
    endtask

    // watchdog
    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'h5eed_1234));
        for (int d = 0; d < 2; d++) begin
            rc[d] = 0; wc[d] = 0; rerr_exp[d] = 0; werr_exp[d] = 0;
        end
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;

        // R1: idle after reset
        step("R1", 0, '0, 0, '0, 0, 0, 0, 0);
        step("R1", 1, 32'h80, 1, 32'h90, 0, 0, 0, 0);
        drain();

        // R3: overlap of distinct words in concurrent mode
        step("R3", 1, 32'h100, 0, '0, 0, 0, 0, 0);
        step("R3", 0, '0, 1, 32'h200, 0, 0, 0, 0);
        step("R3", 1, 32'h104, 1, 32'h208, 0, 0, 0, 0);
        drain();

        // R4: same word with different byte offsets collides
        step("R4", 1, 32'h100, 0, '0, 0, 0, 0, 0);
        step("R4", 0, '0, 1, 32'h103, 0, 0, 0, 0);
        step("R4", 0, '0, 1, 32'h104, 0, 0, 0, 0);
        step("R4", 1, 32'h106, 0, '0, 0, 0, 0, 0);
        drain();
        step("R4", 1, 32'h300, 1, 32'h302, 0, 0, 0, 0);
        step("R4", 0, '0, 1, 32'h302, 0, 0, 0, 0);
        drain();

        // R2: serialized contest and blocking
        step("R2", 1, 32'h10, 1, 32'h20, 0, 0, 0, 0);
        step("R2", 0, '0, 1, 32'h20, 0, 0, 0, 0);
        drain();
        step("R2", 0, '0, 1, 32'h20, 0, 0, 0, 0);
        step("R2", 1, 32'h10, 0, '0, 0, 0, 0, 0);
        drain();

        // R5 / R8 / R9: fill the read table, stall, free in same cycle
        for (int i = 0; i < DEPTH; i++)
            step("R5", 1, 32'h400 + 32'(i * 4), 0, '0, 0, 0, 0, 0);
        step("R5", 1, 32'h480, 0, '0, 0, 0, 0, 0);
        step("R9", 1, 32'h480, 0, '0, 1, 1, 0, 0);
        step("R8", 1, 32'h480, 1, 32'h480, 0, 0, 0, 0);
        drain();

        // R6: valid without ready frees nothing; order of release
        step("R6", 1, 32'h40, 0, '0, 0, 0, 0, 0);
        step("R6", 1, 32'h44, 0, '0, 0, 0, 0, 0);
        step("R6", 0, '0, 1, 32'h40, 1, 0, 0, 0);
        step("R6", 0, '0, 1, 32'h40, 1, 1, 0, 0);
        step("R6", 0, '0, 1, 32'h40, 0, 0, 0, 0);
        step("R6", 0, '0, 1, 32'h44, 0, 0, 0, 0);
        drain();

        // R7: orphan completions
        step("R7", 0, '0, 0, '0, 0, 0, 1, 1);
        step("R7", 0, '0, 0, '0, 1, 1, 0, 0);
        step("R7", 0, '0, 0, '0, 0, 0, 0, 0);
        step("R7", 0, '0, 0, '0, 0, 0, 0, 0);

        // random mix, word pool of 6 with random byte offsets
        for (int n = 0; n < 4000; n++) begin
            step("R4",
                 1'($urandom % 2), 32'h4000 + 32'(($urandom % 6) * 4 + $urandom % 4),
                 1'($urandom % 2), 32'h4000 + 32'(($urandom % 6) * 4 + $urandom % 4),
                 1'(($urandom % 3) == 0), 1'($urandom % 2),
                 1'(($urandom % 3) == 0), 1'($urandom % 2));
        end
        drain();

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule